// File: doc/BRIEF.md
# Tag-Renaming Dispatch Window with Single Function Unit

This block is a small dynamic scheduler. It keeps an architectural register file in which every register has a value, a ready bit and a rename tag. It also keeps a pool of free tags and a window of waiting instructions that feed one function unit. Each dispatched instruction gets a fresh tag for its result. The instruction reads each source either as a finished value or as the tag of the instruction that will produce it. It then waits in the window until both sources are known.

The function unit sits outside the block. It takes an issued instruction when `fu_free` is high. Later it drives the result back on the completion bus as a tag and value pair. That broadcast does three things in the same cycle:
- it fills every waiting operand that carries the tag;
- it writes the register that still names the tag;
- it returns the tag to the pool.

A read port shows any register's ready bit, tag and value.

Top module: `tag_rs_core`

## Requirements
- R1: After reset, register i holds value i with its ready bit set, all tags are free, the window is empty (`iss_valid` low) and `disp_ready` is high.
- R2: A dispatch takes the lowest-numbered free tag as its destination tag. A tag returned in the same cycle is not handed out in that cycle.
- R3: At dispatch, a source register whose ready bit is set gives its value and the operand is marked ready. Otherwise the operand records the register's tag and waits.
- R4: At dispatch, the destination register becomes not ready and its tag becomes the new destination tag, one cycle after the accepting edge. A later writer of the same register replaces an earlier one.
- R5: An entry with both operands ready is presented on the issue port with its opcode, destination tag and both operand values. While `fu_free` is low it stays presented. On the edge where `fu_free` is high it leaves the window.
- R6: A completion broadcast marks ready every waiting operand whose tag equals `cmp_tag`, and gives it `cmp_value`.
- R7: A broadcast writes a register only if that register is not ready and its tag equals `cmp_tag`. The register then becomes ready with `cmp_value`. A register that has been renamed again is left untouched.
- R8: A broadcast returns its tag to the pool, so the next dispatch can use it.
- R9: `disp_ready` is low when the window is full or no tag is free. A dispatch offered while `disp_ready` is low changes nothing.
- R10: When a dispatch reads a register whose tag is broadcast in the same cycle, the new entry captures the broadcast value and is ready at once.
- R11: When several entries are ready, the one dispatched earliest issues first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OPW | Opcode of the dispatched instruction |
| disp_dst | input | log2(NREG) | Destination register |
| disp_src_a | input | log2(NREG) | First source register |
| disp_src_b | input | log2(NREG) | Second source register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| iss_valid | output | 1 | A ready entry is offered to the function unit |
| iss_op | output | OPW | Opcode of the offered entry |
| iss_dtag | output | log2(NTAG) | Destination tag of the offered entry |
| iss_opa | output | DW | First operand value |
| iss_opb | output | DW | Second operand value |
| fu_free | input | 1 | Function unit accepts the offered entry |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | log2(NTAG) | Broadcast tag |
| cmp_value | input | DW | Broadcast result |
| rd_addr | input | log2(NREG) | Register selected for observation |
| rd_ready | output | 1 | Ready bit of the selected register |
| rd_tag | output | log2(NTAG) | Tag of the selected register |
| rd_value | output | DW | Value of the selected register |

## Verification
Two situations are hard to reach from the ports, because each needs the function unit to hold results back.

The first is an exhausted tag pool while the window still has room. The stimulus issues eight independent instructions and withholds every completion, then releases a single broadcast and watches `disp_ready` recover.

The second is a broadcast that lands in the very cycle a dispatch reads the matching register, together with a stale broadcast for a register that has already been renamed again. The bench's scripted function-unit queue releases a result only in a cycle it chooses, and these directed cases run ahead of a long randomized phase.

// File: rtl/tag_rs_pkg.sv
package tag_rs_pkg;
   // default geometry shared by the core, its checker and its users
   localparam int DEF_NREG = 8;
   localparam int DEF_NTAG = 8;
   localparam int DEF_NENT = 4;
   localparam int DEF_DW   = 16;
   localparam int DEF_OPW  = 2;
endpackage

// File: rtl/tag_rs_pool.sv
module tag_rs_pool #(
   parameter int NTAG = 8,
   localparam int TW  = $clog2(NTAG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            give,
   input  logic [TW-1:0]   give_tag,
   output logic            empty,
   output logic [TW-1:0]   pick_tag,
   output logic [NTAG-1:0] free_mask
);
   logic [NTAG-1:0] free_q;
   logic [NTAG-1:0] free_d;

   // lowest-numbered free tag
   always_comb begin
      pick_tag = '0;
      for (int i = NTAG - 1; i >= 0; i--) begin
         if (free_q[i]) pick_tag = TW'(i);
      end
   end

   assign empty     = (free_q == '0);
   assign free_mask = free_q;

   always_comb begin
      free_d = free_q;
      if (take) free_d[pick_tag] = 1'b0;
      if (give) free_d[give_tag] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= '1;
      else        free_q <= free_d;
   end
endmodule

// File: rtl/tag_rs_regfile.sv
module tag_rs_regfile #(
   parameter int NREG = 8,
   parameter int NTAG = 8,
   parameter int DW   = 16,
   localparam int RW  = $clog2(NREG),
   localparam int TW  = $clog2(NTAG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ren_en,
   input  logic [RW-1:0]        ren_reg,
   input  logic [TW-1:0]        ren_tag,
   input  logic                 bc_valid,
   input  logic [TW-1:0]        bc_tag,
   input  logic [DW-1:0]        bc_val,
   input  logic [1:0][RW-1:0]   src_idx,
   output logic [1:0]           src_rdy,
   output logic [1:0][TW-1:0]   src_tag,
   output logic [1:0][DW-1:0]   src_val,
   input  logic [RW-1:0]        obs_idx,
   output logic                 obs_rdy,
   output logic [TW-1:0]        obs_tag,
   output logic [DW-1:0]        obs_val
);
   logic          rdy_q [NREG];
   logic [TW-1:0] tag_q [NREG];
   logic [DW-1:0] val_q [NREG];

   // source read ports with same-cycle broadcast forwarding
   for (genvar p = 0; p < 2; p++) begin : g_src
      logic hit;
      assign hit        = !rdy_q[src_idx[p]] && bc_valid && (tag_q[src_idx[p]] == bc_tag);
      assign src_rdy[p] = rdy_q[src_idx[p]] | hit;
      assign src_tag[p] = tag_q[src_idx[p]];
      assign src_val[p] = rdy_q[src_idx[p]] ? val_q[src_idx[p]] : bc_val;
   end

   assign obs_rdy = rdy_q[obs_idx];
   assign obs_tag = tag_q[obs_idx];
   assign obs_val = val_q[obs_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            rdy_q[i] <= 1'b1;
            tag_q[i] <= '0;
            val_q[i] <= DW'(i);
         end
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (ren_en && ren_reg == RW'(i)) begin
               rdy_q[i] <= 1'b0;
               tag_q[i] <= ren_tag;
            end else if (bc_valid && !rdy_q[i] && tag_q[i] == bc_tag) begin
               rdy_q[i] <= 1'b1;
               val_q[i] <= bc_val;
            end
         end
      end
   end
endmodule

// File: rtl/tag_rs_station.sv
module tag_rs_station #(
   parameter int NENT = 4,
   parameter int NTAG = 8,
   parameter int DW   = 16,
   parameter int OPW  = 2,
   localparam int TW  = $clog2(NTAG),
   localparam int EW  = $clog2(NENT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [OPW-1:0]      in_op,
   input  logic [TW-1:0]       in_dtag,
   input  logic [1:0]          in_rdy,
   input  logic [1:0][TW-1:0]  in_tag,
   input  logic [1:0][DW-1:0]  in_val,
   input  logic                bc_valid,
   input  logic [TW-1:0]       bc_tag,
   input  logic [DW-1:0]       bc_val,
   input  logic                fu_free,
   output logic                full,
   output logic                iss_valid,
   output logic [OPW-1:0]      iss_op,
   output logic [TW-1:0]       iss_dtag,
   output logic [DW-1:0]       iss_opa,
   output logic [DW-1:0]       iss_opb,
   output logic [NENT-1:0]     slot_vld
);
   typedef struct packed {
      logic          rdy;
      logic [TW-1:0] tag;
      logic [DW-1:0] val;
   } opnd_t;

   typedef struct packed {
      logic           vld;
      logic [OPW-1:0] op;
      logic [TW-1:0]  dtag;
      opnd_t [1:0]    src;
   } slot_t;

   slot_t         ent_q [NENT];
   slot_t         ent_d [NENT];
   slot_t         woke  [NENT+1];
   logic [EW-1:0] sel;
   logic          any_rdy;
   logic          do_iss;

   // oldest ready entry: slots are kept compacted, index 0 is oldest
   always_comb begin
      any_rdy = 1'b0;
      sel     = '0;
      for (int i = NENT - 1; i >= 0; i--) begin
         if (ent_q[i].vld && ent_q[i].src[0].rdy && ent_q[i].src[1].rdy) begin
            any_rdy = 1'b1;
            sel     = EW'(i);
         end
      end
   end

   assign do_iss = any_rdy & fu_free;

   // wakeup from the result bus
   always_comb begin
      for (int i = 0; i < NENT; i++) begin
         woke[i] = ent_q[i];
         for (int p = 0; p < 2; p++) begin
            if (bc_valid && ent_q[i].vld && !ent_q[i].src[p].rdy &&
                ent_q[i].src[p].tag == bc_tag) begin
               woke[i].src[p].rdy = 1'b1;
               woke[i].src[p].val = bc_val;
            end
         end
      end
      woke[NENT] = '0;
   end

   // remove the issued slot by shifting younger ones down, then append
   always_comb begin
      logic placed;
      placed = 1'b0;
      for (int i = 0; i < NENT; i++) begin
         if (do_iss && i >= int'(sel)) ent_d[i] = woke[i+1];
         else                          ent_d[i] = woke[i];
      end
      for (int i = 0; i < NENT; i++) begin
         if (in_valid && !placed && !ent_d[i].vld) begin
            ent_d[i].vld  = 1'b1;
            ent_d[i].op   = in_op;
            ent_d[i].dtag = in_dtag;
            for (int p = 0; p < 2; p++) begin
               ent_d[i].src[p].rdy = in_rdy[p];
               ent_d[i].src[p].tag = in_tag[p];
               ent_d[i].src[p].val = in_val[p];
            end
            placed = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) ent_q[i] <= '0;
      end else begin
         ent_q <= ent_d;
      end
   end

   assign full      = ent_q[NENT-1].vld;
   assign iss_valid = any_rdy;
   assign iss_op    = ent_q[sel].op;
   assign iss_dtag  = ent_q[sel].dtag;
   assign iss_opa   = ent_q[sel].src[0].val;
   assign iss_opb   = ent_q[sel].src[1].val;

   for (genvar i = 0; i < NENT; i++) begin : g_vld
      assign slot_vld[i] = ent_q[i].vld;
   end
endmodule

// File: rtl/tag_rs_core.sv
module tag_rs_core #(
   parameter int NREG = tag_rs_pkg::DEF_NREG,
   parameter int NTAG = tag_rs_pkg::DEF_NTAG,
   parameter int NENT = tag_rs_pkg::DEF_NENT,
   parameter int DW   = tag_rs_pkg::DEF_DW,
   parameter int OPW  = tag_rs_pkg::DEF_OPW,
   localparam int RW  = $clog2(NREG),
   localparam int TW  = $clog2(NTAG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           disp_valid,
   input  logic [OPW-1:0] disp_op,
   input  logic [RW-1:0]  disp_dst,
   input  logic [RW-1:0]  disp_src_a,
   input  logic [RW-1:0]  disp_src_b,
   output logic           disp_ready,
   output logic           iss_valid,
   output logic [OPW-1:0] iss_op,
   output logic [TW-1:0]  iss_dtag,
   output logic [DW-1:0]  iss_opa,
   output logic [DW-1:0]  iss_opb,
   input  logic           fu_free,
   input  logic           cmp_valid,
   input  logic [TW-1:0]  cmp_tag,
   input  logic [DW-1:0]  cmp_value,
   input  logic [RW-1:0]  rd_addr,
   output logic           rd_ready,
   output logic [TW-1:0]  rd_tag,
   output logic [DW-1:0]  rd_value
);
   if (NREG < 2) begin : g_bad_nreg
      $error("tag_rs_core: NREG must be at least 2");
   end
   if (NENT < 2) begin : g_bad_nent
      $error("tag_rs_core: NENT must be at least 2");
   end
   if (NTAG <= NENT) begin : g_bad_ntag
      $error("tag_rs_core: NTAG must exceed NENT so issued work can stay in flight");
   end

   logic              pool_empty;
   logic              win_full;
   logic              disp_fire;
   logic [TW-1:0]     new_tag;
   logic [NTAG-1:0]   tag_free;
   logic [NENT-1:0]   ent_vld;
   logic [1:0]        op_rdy;
   logic [1:0][TW-1:0] op_tag;
   logic [1:0][DW-1:0] op_val;

   assign disp_ready = !win_full && !pool_empty;
   assign disp_fire  = disp_valid && disp_ready;

   tag_rs_pool #(.NTAG(NTAG)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (disp_fire),
      .give      (cmp_valid),
      .give_tag  (cmp_tag),
      .empty     (pool_empty),
      .pick_tag  (new_tag),
      .free_mask (tag_free)
   );

   tag_rs_regfile #(.NREG(NREG), .NTAG(NTAG), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ren_en   (disp_fire),
      .ren_reg  (disp_dst),
      .ren_tag  (new_tag),
      .bc_valid (cmp_valid),
      .bc_tag   (cmp_tag),
      .bc_val   (cmp_value),
      .src_idx  ({disp_src_b, disp_src_a}),
      .src_rdy  (op_rdy),
      .src_tag  (op_tag),
      .src_val  (op_val),
      .obs_idx  (rd_addr),
      .obs_rdy  (rd_ready),
      .obs_tag  (rd_tag),
      .obs_val  (rd_value)
   );

   tag_rs_station #(.NENT(NENT), .NTAG(NTAG), .DW(DW), .OPW(OPW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (disp_fire),
      .in_op     (disp_op),
      .in_dtag   (new_tag),
      .in_rdy    (op_rdy),
      .in_tag    (op_tag),
      .in_val    (op_val),
      .bc_valid  (cmp_valid),
      .bc_tag    (cmp_tag),
      .bc_val    (cmp_value),
      .fu_free   (fu_free),
      .full      (win_full),
      .iss_valid (iss_valid),
      .iss_op    (iss_op),
      .iss_dtag  (iss_dtag),
      .iss_opa   (iss_opa),
      .iss_opb   (iss_opb),
      .slot_vld  (ent_vld)
   );
endmodule

// File: rtl/tag_rs_chk.sv
module tag_rs_chk #(
   parameter int NREG = 8,
   parameter int NTAG = 8,
   parameter int NENT = 4,
   parameter int DW   = 16,
   localparam int RW  = $clog2(NREG),
   localparam int TW  = $clog2(NTAG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            fire,
   input logic [RW-1:0]   disp_dst,
   input logic [TW-1:0]   new_tag,
   input logic [NTAG-1:0] tag_free,
   input logic [NENT-1:0] ent_vld,
   input logic            iss_valid,
   input logic            fu_free,
   input logic            cmp_valid,
   input logic [TW-1:0]   cmp_tag,
   input logic [DW-1:0]   cmp_value,
   input logic [RW-1:0]   rd_addr,
   input logic            rd_ready,
   input logic [TW-1:0]   rd_tag,
   input logic [DW-1:0]   rd_value
);
   // R4
   rename_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (rd_addr != $past(disp_dst)) || (!rd_ready && rd_tag == $past(new_tag)));

   // R7
   bcast_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !rd_ready && rd_tag == cmp_tag && !(fire && disp_dst == rd_addr))
      |=> (rd_addr != $past(rd_addr)) || (rd_ready && rd_value == $past(cmp_value)));

   // R5
   iss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !fu_free) |=> iss_valid);

   // R8
   bcast_tag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> !tag_free[cmp_tag]);

   // R11
   slots_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({1'b0, ent_vld} + {{NENT{1'b0}}, 1'b1}));
endmodule

bind tag_rs_core tag_rs_chk #(.NREG(NREG), .NTAG(NTAG), .NENT(NENT), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fire      (disp_fire),
   .disp_dst  (disp_dst),
   .new_tag   (new_tag),
   .tag_free  (tag_free),
   .ent_vld   (ent_vld),
   .iss_valid (iss_valid),
   .fu_free   (fu_free),
   .cmp_valid (cmp_valid),
   .cmp_tag   (cmp_tag),
   .cmp_value (cmp_value),
   .rd_addr   (rd_addr),
   .rd_ready  (rd_ready),
   .rd_tag    (rd_tag),
   .rd_value  (rd_value)
);

// File: tb/sim_tag_rs_core.sv
module sim_tag_rs_core;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int NTAG = 8;
   localparam int NENT = 4;
   localparam int DW   = 16;
   localparam int OPW  = 2;
   localparam int RW   = $clog2(NREG);
   localparam int TW   = $clog2(NTAG);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           disp_valid = 1'b0;
   logic [OPW-1:0] disp_op = '0;
   logic [RW-1:0]  disp_dst = '0;
   logic [RW-1:0]  disp_src_a = '0;
   logic [RW-1:0]  disp_src_b = '0;
   logic           disp_ready;
   logic           iss_valid;
   logic [OPW-1:0] iss_op;
   logic [TW-1:0]  iss_dtag;
   logic [DW-1:0]  iss_opa;
   logic [DW-1:0]  iss_opb;
   logic           fu_free = 1'b0;
   logic           cmp_valid = 1'b0;
   logic [TW-1:0]  cmp_tag = '0;
   logic [DW-1:0]  cmp_value = '0;
   logic [RW-1:0]  rd_addr = '0;
   logic           rd_ready;
   logic [TW-1:0]  rd_tag;
   logic [DW-1:0]  rd_value;

   always #(CLK_PERIOD/2) clk = ~clk;

   tag_rs_core #(.NREG(NREG), .NTAG(NTAG), .NENT(NENT), .DW(DW), .OPW(OPW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_ready(disp_ready),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dtag(iss_dtag),
      .iss_opa(iss_opa), .iss_opb(iss_opb), .fu_free(fu_free),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
      .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_value(rd_value)
   );

   // behavioural reference: plain arrays and queues
   typedef struct {
      int op; int dtag;
      bit r1; int t1; int v1;
      bit r2; int t2; int v2;
   } ment_t;
   typedef struct { int tag; int val; } fres_t;

   ment_t mq[$];
   fres_t fq[$];
   bit    m_rdy  [NREG];
   int    m_tag  [NREG];
   int    m_val  [NREG];
   bit    m_free [NTAG];
   int    n_chk = 0;
   int    n_err = 0;

   function automatic int alu(int op, int a, int b);
      int r;
      case (op)
         0: r = a + b;
         1: r = a - b;
         2: r = a ^ b;
         default: r = a & b;
      endcase
      return r & ((1 << DW) - 1);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int low_free();
      for (int t = 0; t < NTAG; t++) if (m_free[t]) return t;
      return -1;
   endfunction

   function automatic int first_ready();
      foreach (mq[i]) if (mq[i].r1 && mq[i].r2) return i;
      return -1;
   endfunction

   // one clock: drive, compare against the model, advance the model
   task automatic cyc(bit dv, int op, int d, int s1, int s2, bit ff, bit cv, int ra);
      int  k, nt, bt, bv;
      bit  exp_dr, fire, bc;
      ment_t ne;
      @(negedge clk);
      bc = cv && (fq.size() > 0);
      disp_valid = dv;
      disp_op    = OPW'(op);
      disp_dst   = RW'(d);
      disp_src_a = RW'(s1);
      disp_src_b = RW'(s2);
      fu_free    = ff;
      cmp_valid  = bc;
      cmp_tag    = bc ? TW'(fq[0].tag) : '0;
      cmp_value  = bc ? DW'(fq[0].val) : '0;
      rd_addr    = RW'(ra);
      #1;
      exp_dr = (mq.size() < NENT) && (low_free() >= 0);
      k = first_ready();
      chk("R9", "disp_ready", int'(disp_ready), int'(exp_dr));
      chk("R5", "iss_valid", int'(iss_valid), int'(k >= 0));
      if (k >= 0) begin
         chk("R2", "iss_dtag", int'(iss_dtag), mq[k].dtag);
         chk("R5", "iss_op", int'(iss_op), mq[k].op);
         chk("R6", "iss_opa", int'(iss_opa), mq[k].v1);
         chk("R6", "iss_opb", int'(iss_opb), mq[k].v2);
      end
      chk("R7", "rd_ready", int'(rd_ready), int'(m_rdy[ra]));
      if (m_rdy[ra]) chk("R7", "rd_value", int'(rd_value), m_val[ra]);
      else           chk("R4", "rd_tag", int'(rd_tag), m_tag[ra]);

      fire = dv && exp_dr;
      nt   = low_free();
      bt = 0; bv = 0;
      if (bc) begin
         bt = fq[0].tag; bv = fq[0].val;
         void'(fq.pop_front());
      end
      ne.op = op; ne.dtag = nt;
      ne.r1 = 1; ne.t1 = m_tag[s1]; ne.v1 = m_val[s1];
      if (!m_rdy[s1]) begin
         if (bc && m_tag[s1] == bt) ne.v1 = bv; else ne.r1 = 0;
      end
      ne.r2 = 1; ne.t2 = m_tag[s2]; ne.v2 = m_val[s2];
      if (!m_rdy[s2]) begin
         if (bc && m_tag[s2] == bt) ne.v2 = bv; else ne.r2 = 0;
      end
      if (k >= 0 && ff) begin
         fres_t f;
         f.tag = mq[k].dtag;
         f.val = alu(mq[k].op, mq[k].v1, mq[k].v2);
         fq.push_back(f);
         mq.delete(k);
      end
      if (bc) begin
         foreach (mq[i]) begin
            if (!mq[i].r1 && mq[i].t1 == bt) begin mq[i].r1 = 1; mq[i].v1 = bv; end
            if (!mq[i].r2 && mq[i].t2 == bt) begin mq[i].r2 = 1; mq[i].v2 = bv; end
         end
         for (int r = 0; r < NREG; r++) begin
            if (!m_rdy[r] && m_tag[r] == bt) begin m_rdy[r] = 1; m_val[r] = bv; end
         end
         m_free[bt] = 1;
      end
      if (fire) begin
         m_rdy[d] = 0; m_tag[d] = nt; m_free[nt] = 0;
         mq.push_back(ne);
      end
      @(posedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int r = 0; r < NREG; r++) begin m_rdy[r] = 1; m_tag[r] = 0; m_val[r] = r; end
      for (int t = 0; t < NTAG; t++) m_free[t] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      chk("R1", "disp_ready", int'(disp_ready), 1);
      chk("R1", "iss_valid", int'(iss_valid), 0);
      for (int r = 0; r < NREG; r++) begin
         @(negedge clk);
         rd_addr = RW'(r);
         #1;
         chk("R1", "rd_ready", int'(rd_ready), 1);
         chk("R1", "rd_value", int'(rd_value), r);
      end

      // R11 oldest first, R3 ready sources give values, R4 rename
      cyc(1, 0, 1, 2, 3, 0, 0, 1);
      cyc(1, 1, 4, 5, 6, 0, 0, 4);
      #2;
      chk("R11", "oldest iss_dtag", int'(iss_dtag), 0);
      chk("R3", "iss_opa", int'(iss_opa), 2);
      chk("R3", "iss_opb", int'(iss_opb), 3);
      chk("R4", "renamed rd_ready", int'(rd_ready), 0);
      chk("R4", "renamed rd_tag", int'(rd_tag), 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 1);
      #2;
      chk("R5", "next issue after removal", int'(iss_dtag), 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 0, 0, 1, 1);
      #2;
      chk("R7", "written rd_ready", int'(rd_ready), 1);
      chk("R7", "written rd_value", int'(rd_value), 5);

      // R10 broadcast forwarded into a same-cycle dispatch
      cyc(1, 0, 1, 1, 2, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 1);
      cyc(1, 0, 3, 1, 1, 0, 1, 3);
      #2;
      chk("R10", "forwarded entry ready", int'(iss_valid), 1);
      chk("R10", "forwarded opa", int'(iss_opa), 7);
      chk("R10", "forwarded opb", int'(iss_opb), 7);
      chk("R2", "no same-cycle tag reuse", int'(iss_dtag), 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 3);
      cyc(0, 0, 0, 0, 0, 0, 1, 3);

      // R7 stale broadcast after the register was renamed again
      cyc(1, 0, 5, 6, 6, 1, 0, 5);
      cyc(1, 2, 5, 0, 0, 1, 0, 5);
      cyc(0, 0, 0, 0, 0, 0, 1, 5);
      #2;
      chk("R7", "stale broadcast rd_ready", int'(rd_ready), 0);
      chk("R7", "stale broadcast rd_tag", int'(rd_tag), 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 5);
      cyc(0, 0, 0, 0, 0, 0, 1, 5);
      #2;
      chk("R7", "latest writer rd_value", int'(rd_value), 0);

      // R9 and R8: exhaust the tag pool while the window has room
      for (int i = 0; i < NTAG; i++) cyc(1, 0, 1 + (i % 7), 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
      #2;
      chk("R9", "pool empty disp_ready", int'(disp_ready), 0);
      chk("R9", "pool empty iss_valid", int'(iss_valid), 0);
      cyc(1, 0, 2, 0, 0, 1, 0, 2);
      #2;
      chk("R9", "ignored dispatch disp_ready", int'(disp_ready), 0);
      cyc(0, 0, 0, 0, 0, 1, 1, 0);
      #2;
      chk("R8", "tag returned disp_ready", int'(disp_ready), 1);
      cyc(1, 0, 7, 0, 0, 0, 0, 7);
      #2;
      chk("R8", "returned tag reused", int'(rd_tag), 0);
      repeat (12) cyc(0, 0, 0, 0, 0, 1, 1, 0);

      // R9: full window
      for (int i = 0; i < NENT; i++) cyc(1, 3, i + 1, 0, 0, 0, 0, 0);
      #2;
      chk("R9", "full disp_ready", int'(disp_ready), 0);
      cyc(1, 0, 7, 0, 0, 0, 0, 7);
      #2;
      chk("R9", "ignored dispatch rd_ready", int'(rd_ready), 1);
      repeat (10) cyc(0, 0, 0, 0, 0, 1, 1, 0);

      // mixed traffic against the reference model
      repeat (800) begin
         cyc(($urandom % 10) < 6, $urandom % 4, $urandom % NREG, $urandom % NREG,
             $urandom % NREG, ($urandom % 10) < 7, ($urandom % 2) == 1, $urandom % NREG);
      end
      repeat (40) cyc(0, 0, 0, 0, 0, 1, 1, $urandom % NREG);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule